// File: doc/BRIEF.md
# Macrocycle and Bus-Gap Timers

This block supplies the timing counters that a fieldbus master's control processor reads while it sequences traffic. A cycle timer counts system clock periods up to a length that the processor programs once at startup. It then restarts from zero, and each restart adds one to a count of completed macrocycles kept since reset.

Two gap timers, one for turnaround and one for silence, each take their own programmed length. Each is armed by its own start pulse and raises a sticky done flag when it expires.

Every time counter is shown on a status word. The low bits hold the count and the top bit shows whether the counter is running. The macrocycle number comes out on a status word of its own. Register decode and frame sequencing sit outside the block.

Top module: `busgap_cycle_timers`

## Requirements
- R1: While reset is asserted, all counters, running bits, done flags and the macrocycle number read 0.
- R2: With a non-zero cycle length, the cycle count rises by one on every clock edge, and the running bit (top bit of the cycle status word) reads 1.
- R3: When the cycle count holds length minus 1, the next edge returns it to 0 and adds one to the macrocycle number. So after k edges from reset, the count is k mod L and the number is k div L.
- R4: A cycle length of 0 holds the cycle count at 0 with the running bit clear and leaves the macrocycle number unchanged. A later non-zero length restarts the counting from 0.
- R5: A start pulse on a gap timer with non-zero length loads its count with 0 and sets its running bit (top bit of its status word) on that edge. The count then rises by one per edge.
- R6: k edges after the start edge, a gap timer's count reads min(k, L), its running bit reads k < L and its done flag reads k >= L. Done stays set and the count stays at L until the next start pulse or until the length becomes 0.
- R7: A start pulse while a gap timer runs, or after it has expired, clears its done flag and restarts its count from 0. Expiry then comes L edges after the new start.
- R8: A gap timer whose length is 0 holds its count, running bit and done flag at 0 and ignores start pulses.
- R9: The turnaround and silence timers are independent. Activity on one leaves the other's status word and done flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| cycle_len_i | input | CNT_W | Macrocycle length in clock periods, 0 stops the timer |
| turn_len_i | input | CNT_W | Turnaround length in clock periods, 0 stops the timer |
| turn_start_i | input | 1 | Start or restart pulse for the turnaround timer |
| quiet_len_i | input | CNT_W | Silence length in clock periods, 0 stops the timer |
| quiet_start_i | input | 1 | Start or restart pulse for the silence timer |
| cycle_stat_o | output | CNT_W+1 | Running bit over the macrocycle count |
| cycle_num_o | output | NUM_W | Macrocycles completed since reset |
| turn_stat_o | output | CNT_W+1 | Running bit over the turnaround count |
| turn_done_o | output | 1 | Turnaround expired, sticky until restart |
| quiet_stat_o | output | CNT_W+1 | Running bit over the silence count |
| quiet_done_o | output | 1 | Silence expired, sticky until restart |

## Verification
The hardest case to reach from the ports is a gap timer restarted in the middle of a run. The second start has to land at a known count, and the bench then has to show that expiry is measured from the new start and not from the old one. The stimulus pulses start, lets three edges pass, and pulses start again. It then tracks the count edge by edge until expiry.

Lengths of 1 are swept for both timer kinds, because there the wrap edge and the expiry edge fall on the very first edge. The bench also changes the cycle length to 0 and back in the middle of a count, which shows that the macrocycle number freezes and then resumes from the value it held.

// File: rtl/bct_pkg.sv
`timescale 1ns/1ps
package bct_pkg;
   // Gap timer slots inside the top level
   localparam int GAP_TIMERS = 2;
   localparam int GAP_TURN   = 0;
   localparam int GAP_QUIET  = 1;
   // Widest counter the library accepts
   localparam int MAX_CNT_W  = 62;
   localparam int MIN_CNT_W  = 2;
endpackage

// File: rtl/bct_cycle_counter.sv
`timescale 1ns/1ps
module bct_cycle_counter #(
   parameter int CNT_W = 31
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [CNT_W-1:0] len_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             wrap_o
);
   import bct_pkg::*;

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("bct_cycle_counter: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             len_zero;
   logic             at_end;

   assign len_zero = (len_i == '0);
   // greater-or-equal keeps the counter bounded if the length shrinks
   assign at_end   = !len_zero && (cnt_q >= (len_i - ONE));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (len_zero) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         cnt_q <= at_end ? '0 : cnt_q + ONE;
      end
   end

   assign cnt_o  = cnt_q;
   assign run_o  = run_q;
   assign wrap_o = at_end;

   // R2: count advances by one below the end value
   a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (len_i != '0 && (cnt_q + ONE) < len_i) |=> (cnt_q == $past(cnt_q) + ONE) && run_q);

   // R3: a wrap returns the count to zero
   a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wrap_o |=> (cnt_q == '0) && run_q);

   // R4: zero length stops and clears
   a_r4_zero_stops: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (len_i == '0) |=> (cnt_q == '0) && !run_q);
endmodule

// File: rtl/bct_event_counter.sv
`timescale 1ns/1ps
module bct_event_counter #(
   parameter int NUM_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             inc_i,
   output logic [NUM_W-1:0] cnt_o
);
   localparam logic [NUM_W-1:0] ONE = {{(NUM_W-1){1'b0}}, 1'b1};

   generate
      if (NUM_W < 1 || NUM_W > 64) begin : g_bad_width
         $error("bct_event_counter: NUM_W out of range");
      end
   endgenerate

   logic [NUM_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)   cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

   // R3: each wrap pulse adds exactly one
   a_r3_num_inc: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      inc_i |=> (cnt_q == $past(cnt_q) + ONE));

   // R4: no wrap, no change
   a_r4_num_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/bct_gap_timer.sv
`timescale 1ns/1ps
module bct_gap_timer #(
   parameter int CNT_W = 31
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             start_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             done_o
);
   import bct_pkg::*;

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("bct_gap_timer: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             run_q;
   logic             done_q;
   logic             len_zero;
   logic             expire;

   assign len_zero = (len_i == '0);
   assign cnt_inc  = cnt_q + ONE;
   // while running cnt_q < len_i, so the increment cannot overflow
   assign expire   = run_q && (cnt_inc >= len_i);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (len_zero) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_inc;
         if (expire) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign run_o  = run_q;
   assign done_o = done_q;

   // R5: running count steps by one before expiry
   a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (run_q && !start_i && len_i != '0 && cnt_inc < len_i) |=> run_q && (cnt_q == $past(cnt_q) + ONE));

   // R6: done and running never both set
   a_r6_done_excl: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_q |-> !run_q);

   // R6: done is sticky
   a_r6_done_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (done_q && !start_i && len_i != '0) |=> done_q && $stable(cnt_q));

   // R7: start restarts from zero
   a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && len_i != '0) |=> run_q && !done_q && (cnt_q == '0));

   // R8: zero length keeps the timer idle
   a_r8_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (len_i == '0) |=> (cnt_q == '0) && !run_q && !done_q);
endmodule

// File: rtl/busgap_cycle_timers.sv
`timescale 1ns/1ps
module busgap_cycle_timers #(
   parameter int CNT_W = 31,
   parameter int NUM_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [CNT_W-1:0] cycle_len_i,
   input  logic [CNT_W-1:0] turn_len_i,
   input  logic             turn_start_i,
   input  logic [CNT_W-1:0] quiet_len_i,
   input  logic             quiet_start_i,
   output logic [CNT_W:0]   cycle_stat_o,
   output logic [NUM_W-1:0] cycle_num_o,
   output logic [CNT_W:0]   turn_stat_o,
   output logic             turn_done_o,
   output logic [CNT_W:0]   quiet_stat_o,
   output logic             quiet_done_o
);
   import bct_pkg::*;

   localparam int STAT_W = CNT_W + 1;

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_cnt
         $error("busgap_cycle_timers: CNT_W out of range");
      end
      if (NUM_W < 1 || NUM_W > 64) begin : g_bad_num
         $error("busgap_cycle_timers: NUM_W out of range");
      end
   endgenerate

   // macrocycle timer and its completion counter
   logic [CNT_W-1:0] cyc_cnt;
   logic             cyc_run;
   logic             cyc_wrap;

   bct_cycle_counter #(.CNT_W(CNT_W)) cycle_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .len_i   (cycle_len_i),
      .cnt_o   (cyc_cnt),
      .run_o   (cyc_run),
      .wrap_o  (cyc_wrap)
   );

   bct_event_counter #(.NUM_W(NUM_W)) cycnum_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .inc_i   (cyc_wrap),
      .cnt_o   (cycle_num_o)
   );

   assign cycle_stat_o = {cyc_run, cyc_cnt};

   // gap timers, one slot each
   logic [CNT_W-1:0]  gap_len   [GAP_TIMERS];
   logic              gap_start [GAP_TIMERS];
   logic [CNT_W-1:0]  gap_cnt   [GAP_TIMERS];
   logic              gap_run   [GAP_TIMERS];
   logic              gap_done  [GAP_TIMERS];
   logic [STAT_W-1:0] gap_stat  [GAP_TIMERS];

   assign gap_len[GAP_TURN]    = turn_len_i;
   assign gap_start[GAP_TURN]  = turn_start_i;
   assign gap_len[GAP_QUIET]   = quiet_len_i;
   assign gap_start[GAP_QUIET] = quiet_start_i;

   generate
      for (genvar g = 0; g < GAP_TIMERS; g++) begin : g_gap
         bct_gap_timer #(.CNT_W(CNT_W)) gap_i (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .len_i   (gap_len[g]),
            .start_i (gap_start[g]),
            .cnt_o   (gap_cnt[g]),
            .run_o   (gap_run[g]),
            .done_o  (gap_done[g])
         );
         assign gap_stat[g] = {gap_run[g], gap_cnt[g]};
      end
   endgenerate

   assign turn_stat_o  = gap_stat[GAP_TURN];
   assign turn_done_o  = gap_done[GAP_TURN];
   assign quiet_stat_o = gap_stat[GAP_QUIET];
   assign quiet_done_o = gap_done[GAP_QUIET];

   // R9: a timer's start pulse never disturbs the other one's done flag
   a_r9_turn_isolated: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!turn_start_i && $stable(turn_len_i) && turn_done_o && turn_len_i != '0) |=> turn_done_o);
endmodule

// File: tb/busgap_cycle_timers_tb.sv
`timescale 1ns/1ps
module busgap_cycle_timers_tb_top;
   localparam int CW = 31;
   localparam int NW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cyc_len = '0;
   logic [CW-1:0] ta_len = '0;
   logic [CW-1:0] sil_len = '0;
   logic          ta_start = 1'b0;
   logic          sil_start = 1'b0;
   logic [CW:0]   cyc_stat;
   logic [NW-1:0] cyc_num;
   logic [CW:0]   ta_stat;
   logic [CW:0]   sil_stat;
   logic          ta_done;
   logic          sil_done;

   int vectors = 0;
   int errors  = 0;

   always #2.5 clk = ~clk;

   busgap_cycle_timers #(.CNT_W(CW), .NUM_W(NW)) dut_i (
      .clk_i         (clk),
      .rst_n_i       (rst_n),
      .cycle_len_i   (cyc_len),
      .turn_len_i    (ta_len),
      .turn_start_i  (ta_start),
      .quiet_len_i   (sil_len),
      .quiet_start_i (sil_start),
      .cycle_stat_o  (cyc_stat),
      .cycle_num_o   (cyc_num),
      .turn_stat_o   (ta_stat),
      .turn_done_o   (ta_done),
      .quiet_stat_o  (sil_stat),
      .quiet_done_o  (sil_done)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic longint g_cnt(input int t);
      return (t == 0) ? longint'(ta_stat[CW-1:0]) : longint'(sil_stat[CW-1:0]);
   endfunction
   function automatic longint g_run(input int t);
      return (t == 0) ? longint'(ta_stat[CW]) : longint'(sil_stat[CW]);
   endfunction
   function automatic longint g_done(input int t);
      return (t == 0) ? longint'(ta_done) : longint'(sil_done);
   endfunction

   task automatic set_len(input int t, input int v);
      if (t == 0) ta_len = CW'(v);
      else        sil_len = CW'(v);
   endtask
   task automatic set_start(input int t, input logic v);
      if (t == 0) ta_start = v;
      else        sil_start = v;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : main
      repeat (3) tick();
      // R1: reset state
      chk("R1", "cycle count", longint'(cyc_stat), 0);
      chk("R1", "cycle number", longint'(cyc_num), 0);
      chk("R1", "turn status", longint'(ta_stat), 0);
      chk("R1", "quiet status", longint'(sil_stat), 0);
      chk("R1", "done flags", longint'({ta_done, sil_done}), 0);

      // R2 R3 R4: macrocycle sweep over lengths 1..6
      for (int len = 1; len <= 6; len++) begin
         int kmax;
         longint numk;
         rst_n = 1'b0;
         cyc_len = CW'(len);
         tick();
         chk("R1", "cycle count in reset", longint'(cyc_stat), 0);
         chk("R1", "cycle number in reset", longint'(cyc_num), 0);
         rst_n = 1'b1;
         kmax = 3 * len + 2;
         for (int k = 1; k <= kmax; k++) begin
            tick();
            chk("R3", "cycle count", longint'(cyc_stat[CW-1:0]), longint'(k % len));
            chk("R2", "cycle running", longint'(cyc_stat[CW]), 1);
            chk("R3", "cycle number", longint'(cyc_num), longint'(k / len));
         end
         numk = longint'(kmax / len);
         cyc_len = '0;
         for (int j = 0; j < 3; j++) begin
            tick();
            chk("R4", "stopped count", longint'(cyc_stat[CW-1:0]), 0);
            chk("R4", "stopped running bit", longint'(cyc_stat[CW]), 0);
            chk("R4", "frozen number", longint'(cyc_num), numk);
            // R8: gap timers idle with zero length
            chk("R8", "turn idle", longint'(ta_stat), 0);
         end
         cyc_len = CW'(len);
         for (int j = 1; j <= len + 1; j++) begin
            tick();
            chk("R4", "resumed count", longint'(cyc_stat[CW-1:0]), longint'(j % len));
            chk("R4", "resumed number", longint'(cyc_num), numk + longint'(j / len));
         end
      end
      cyc_len = '0;

      // R8: start ignored with zero length
      for (int t = 0; t < 2; t++) begin
         set_len(t, 0);
         set_start(t, 1'b1);
         tick();
         chk("R8", "zero-len count", g_cnt(t), 0);
         chk("R8", "zero-len running", g_run(t), 0);
         chk("R8", "zero-len done", g_done(t), 0);
         set_start(t, 1'b0);
         tick();
         chk("R8", "zero-len done later", g_done(t), 0);
      end

      // R5 R6 R9: gap sweep
      for (int t = 0; t < 2; t++) begin
         for (int len = 1; len <= 5; len++) begin
            int o;
            longint o_cnt, o_run, o_done;
            o = 1 - t;
            o_cnt = g_cnt(o);
            o_run = g_run(o);
            o_done = g_done(o);
            set_len(t, len);
            set_start(t, 1'b1);
            tick();
            chk("R5", "count at start", g_cnt(t), 0);
            chk("R5", "running at start", g_run(t), 1);
            chk("R7", "done cleared by start", g_done(t), 0);
            set_start(t, 1'b0);
            for (int k = 1; k <= len + 3; k++) begin
               tick();
               chk("R6", "gap count", g_cnt(t), longint'((k < len) ? k : len));
               chk("R6", "gap running", g_run(t), longint'(k < len));
               chk("R6", "gap done", g_done(t), longint'(k >= len));
            end
            chk("R9", "other count", g_cnt(o), o_cnt);
            chk("R9", "other running", g_run(o), o_run);
            chk("R9", "other done", g_done(o), o_done);
         end
      end

      // R7: restart while running, then R8 clear by zero length
      for (int t = 0; t < 2; t++) begin
         set_len(t, 6);
         set_start(t, 1'b1);
         tick();
         set_start(t, 1'b0);
         repeat (3) tick();
         chk("R5", "count before restart", g_cnt(t), 3);
         set_start(t, 1'b1);
         tick();
         chk("R7", "count after restart", g_cnt(t), 0);
         chk("R7", "running after restart", g_run(t), 1);
         set_start(t, 1'b0);
         for (int k = 1; k <= 7; k++) begin
            tick();
            chk("R7", "restarted count", g_cnt(t), longint'((k < 6) ? k : 6));
            chk("R7", "restarted done", g_done(t), longint'(k >= 6));
         end
         set_len(t, 0);
         tick();
         chk("R8", "done cleared by zero length", g_done(t), 0);
         chk("R8", "status cleared by zero length", (t == 0) ? longint'(ta_stat) : longint'(sil_stat), 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule